// File: doc/BRIEF.md
# UDP Payload Pattern Spotter

This block watches a byte-wide packet stream carrying IPv4/UDP traffic, one byte per cycle whenever a valid qualifier is high. Starting from the first byte of each packet, it walks over a fixed-size IP header and the UDP header without looking at their contents. On the way it extracts the big-endian UDP length field and presents it on a side output for exactly one cycle.

Once the headers are behind it, the block scans the payload for a fixed character sequence, "corn!" by default. It raises a single-cycle alert each time the final character of a complete occurrence arrives. Scanning continues to the end of the packet, so every occurrence is reported.

A start-of-packet flag that comes with a valid byte resynchronises the walker. It works at any point, so a truncated packet never leaves the scanner out of step. Header sizes, the length field offset and width, and the pattern itself are parameters.

Top module: `udp_payload_spotter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `alert_o` and `len_vld_o` are 0 and `len_o` is all zeros.
- R2: A cycle with `in_vld` low changes nothing: the byte and start flag on it are ignored, and both strobes are 0 on the following cycle.
- R3: The first 28 valid bytes of a packet (20 IP header bytes then 8 UDP header bytes) are never pattern-matched, whatever their values.
- R4: Valid packet bytes 24 (upper) and 25 (lower) form the 16-bit length. One cycle after byte 25 is accepted, `len_vld_o` is 1 and `len_o` equals that length. In every other cycle `len_vld_o` is 0 and `len_o` is 0.
- R5: `alert_o` is 1 for one cycle, the cycle after a payload byte 0x21 ('!') is accepted. That byte must complete consecutive valid payload bytes 0x63 0x6F 0x72 0x6E 0x21 ("corn!"). The comparison is exact, so upper-case letters do not match. `alert_o` is 0 otherwise.
- R6: A payload byte that breaks a partial match discards it. If that byte is 0x63 ('c'), it counts as the first character of a new attempt.
- R7: After a complete match, scanning resumes at once, and later occurrences in the same packet each raise their own alert.
- R8: A valid byte with `in_sop` high is taken as header byte 0 of a new packet, whatever state the block is in. Any partial match or partial header walk is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Qualifies `in_byte` and `in_sop` |
| in_sop | input | 1 | First byte of a packet |
| in_byte | input | 8 | Stream byte |
| alert_o | output | 1 | Pattern completed on the previous accepted byte |
| len_vld_o | output | 1 | One-cycle strobe for `len_o` |
| len_o | output | 16 | Captured UDP length, zero when not strobed |

## Verification
The bench builds the block with its default parameters. These are a 20-byte IP header, an 8-byte UDP header, a length field at UDP offset 4 and the five-character pattern. With these values the header boundary falls at byte 28, and a pattern planted in the header can be shown to stay silent. The defaults also make the self-overlap cases reachable: a repeated 'c', a 'c' arriving where '!' is expected, and back-to-back occurrences. Stalls with junk bytes on idle cycles, and start flags arriving mid-header or mid-match, are also exercised at these sizes.

// File: rtl/udp_spot_pkg.sv
package udp_spot_pkg;
   typedef logic [7:0] byte_t;

   // character k (0 = first) of a packed string of n characters
   function automatic byte_t char_at(input logic [255:0] s, input int n, input int k);
      return s[(n-1-k)*8 +: 8];
   endfunction
endpackage

// File: rtl/udp_spot_hdr_walker.sv
module udp_spot_hdr_walker
   import udp_spot_pkg::*;
#(
   parameter int IP_HDR_BYTES  = 20,
   parameter int UDP_HDR_BYTES = 8,
   parameter int LEN_OFS       = 4,
   parameter int LEN_W         = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             in_sop,
   input  byte_t            in_byte,
   output logic             payload_o,
   output logic             len_stb_o,
   output logic [LEN_W-1:0] len_val_o
);
   localparam int HDR_TOTAL  = IP_HDR_BYTES + UDP_HDR_BYTES;
   localparam int CNT_W      = $clog2(HDR_TOTAL + 1);
   localparam int LEN_BYTES  = LEN_W / 8;
   localparam int LEN_HI_POS = IP_HDR_BYTES + LEN_OFS;
   localparam int LEN_LO_POS = LEN_HI_POS + LEN_BYTES - 1;

   logic [CNT_W-1:0] pos_q;
   logic [LEN_W-9:0] acc_q;
   logic             in_field, at_last;

   // byte position of the current beat inside the packet header
   assign in_field  = in_vld && !in_sop && pos_q >= CNT_W'(LEN_HI_POS) && pos_q < CNT_W'(LEN_LO_POS);
   assign at_last   = in_vld && !in_sop && pos_q == CNT_W'(LEN_LO_POS);
   assign payload_o = in_vld && !in_sop && pos_q == CNT_W'(HDR_TOTAL);
   assign len_stb_o = at_last;
   assign len_val_o = at_last ? {acc_q, in_byte} : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (in_vld) begin
         if (in_sop)
            pos_q <= CNT_W'(1);
         else if (pos_q != CNT_W'(HDR_TOTAL))
            pos_q <= pos_q + CNT_W'(1);
      end
   end

   generate
      if (LEN_BYTES > 2) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q <= '0;
            else if (in_field) acc_q <= {acc_q[LEN_W-17:0], in_byte};
         end
      end else begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q <= '0;
            else if (in_field) acc_q <= in_byte;
         end
      end
   endgenerate
endmodule

// File: rtl/udp_spot_matcher.sv
module udp_spot_matcher
   import udp_spot_pkg::*;
#(
   parameter int                 PAT_LEN = 5,
   parameter logic [PAT_LEN*8-1:0] PATTERN = "corn!"
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  restart_i,
   input  logic  step_i,
   input  byte_t in_byte,
   output logic  hit_o
);
   localparam int IDX_W = $clog2(PAT_LEN);

   logic [PAT_LEN-1:0] eq;
   logic [IDX_W-1:0]   idx_q;
   logic               cur_eq;

   // one comparator per pattern position
   for (genvar k = 0; k < PAT_LEN; k++) begin : g_cmp
      assign eq[k] = in_byte == PATTERN[(PAT_LEN-1-k)*8 +: 8];
   end

   assign cur_eq = eq[idx_q];
   assign hit_o  = step_i && cur_eq && idx_q == IDX_W'(PAT_LEN-1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (restart_i) begin
         idx_q <= '0;
      end else if (step_i) begin
         if (cur_eq)
            idx_q <= (idx_q == IDX_W'(PAT_LEN-1)) ? '0 : idx_q + IDX_W'(1);
         else
            idx_q <= eq[0] ? IDX_W'(1) : '0;
      end
   end
endmodule

// File: rtl/udp_payload_spotter.sv
module udp_payload_spotter
   import udp_spot_pkg::*;
#(
   parameter int                   IP_HDR_BYTES  = 20,
   parameter int                   UDP_HDR_BYTES = 8,
   parameter int                   LEN_OFS       = 4,
   parameter int                   LEN_W         = 16,
   parameter int                   PAT_LEN       = 5,
   parameter logic [PAT_LEN*8-1:0] PATTERN       = "corn!"
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             in_sop,
   input  logic [7:0]       in_byte,
   output logic             alert_o,
   output logic             len_vld_o,
   output logic [LEN_W-1:0] len_o
);
   initial begin : param_checks
      assert (LEN_W >= 16 && LEN_W % 8 == 0)
         else $error("LEN_W must be a multiple of 8, at least 16");
      assert (LEN_OFS + LEN_W / 8 <= UDP_HDR_BYTES)
         else $error("length field must fit in the UDP header");
      assert (PAT_LEN >= 2 && PAT_LEN <= 32)
         else $error("PAT_LEN out of range");
      assert (IP_HDR_BYTES >= 1)
         else $error("IP_HDR_BYTES must be positive");
   end

   logic             payload, len_stb, hit;
   logic [LEN_W-1:0] len_val;

   udp_spot_hdr_walker #(
      .IP_HDR_BYTES (IP_HDR_BYTES),
      .UDP_HDR_BYTES(UDP_HDR_BYTES),
      .LEN_OFS      (LEN_OFS),
      .LEN_W        (LEN_W)
   ) walker_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .in_sop   (in_sop),
      .in_byte  (in_byte),
      .payload_o(payload),
      .len_stb_o(len_stb),
      .len_val_o(len_val)
   );

   udp_spot_matcher #(
      .PAT_LEN(PAT_LEN),
      .PATTERN(PATTERN)
   ) matcher_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(in_vld && in_sop),
      .step_i   (payload),
      .in_byte  (in_byte),
      .hit_o    (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alert_o   <= 1'b0;
         len_vld_o <= 1'b0;
         len_o     <= '0;
      end else begin
         alert_o   <= hit;
         len_vld_o <= len_stb;
         len_o     <= len_val;
      end
   end
endmodule

// File: rtl/udp_payload_spotter_chk.sv
module udp_payload_spotter_chk #(
   parameter int         LEN_W     = 16,
   parameter logic [7:0] LAST_CHAR = 8'h21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_vld,
   input logic             in_sop,
   input logic [7:0]       in_byte,
   input logic             alert_o,
   input logic             len_vld_o,
   input logic [LEN_W-1:0] len_o
);
   AST_LEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      len_vld_o |=> !len_vld_o);                                          // R4
   AST_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !len_vld_o |-> len_o == '0);                                        // R4
   AST_ALERT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o |-> $past(in_vld));                                         // R2
   AST_ALERT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o |-> $past(in_byte) == LAST_CHAR);                           // R5
   AST_ALERT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o |=> !alert_o);                                              // R5
   AST_HDR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(alert_o && len_vld_o));                                           // R3
   AST_SOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      alert_o |-> !$past(in_sop));                                        // R8
endmodule

bind udp_payload_spotter udp_payload_spotter_chk #(
   .LEN_W    (LEN_W),
   .LAST_CHAR(PATTERN[7:0])
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_sop   (in_sop),
   .in_byte  (in_byte),
   .alert_o  (alert_o),
   .len_vld_o(len_vld_o),
   .len_o    (len_o)
);

// File: tb/udp_payload_spotter_tb_top.sv
module udp_payload_spotter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic        in_sop = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        alert_o, len_vld_o;
   logic [15:0] len_o;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2 clk = ~clk;

   udp_payload_spotter dut_i (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sop(in_sop),
      .in_byte(in_byte), .alert_o(alert_o), .len_vld_o(len_vld_o), .len_o(len_o)
   );

   typedef struct packed {
      logic [127:0] payload;
      logic [15:0]  mask;   // bit i: alert expected after payload byte i
      logic [15:0]  len;
      logic         gap;    // idle junk beat after every byte
   } vec_t;

   localparam vec_t TBL [6] = '{
      '{"corn!corn!......", 16'h0210, 16'h0024, 1'b0},   // R5 R7
      '{"cocorn!.........", 16'h0040, 16'h1234, 1'b0},   // R6
      '{"corncorn!.......", 16'h0100, 16'hABCD, 1'b1},   // R6 R2
      '{"CORN!corn ......", 16'h0000, 16'h0100, 1'b0},   // R5 exact match
      '{"corn?!corn!.....", 16'h0400, 16'hFFFF, 1'b1},   // R6 R2
      '{"ccorn!..........", 16'h0020, 16'h0001, 1'b0}    // R6
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic s, input logic [7:0] b);
      in_vld = v; in_sop = s; in_byte = b;
      @(posedge clk); #1;
   endtask

   task automatic quiet(input string req);
      check(req, {31'd0, alert_o}, 32'd0);
      check(req, {15'd0, len_vld_o, len_o}, 32'd0);
   endtask

   function automatic logic [7:0] hdr_byte(input int i, input logic [15:0] len, input bit planted);
      if (i == 24) return len[15:8];
      if (i == 25) return len[7:0];
      if (planted && i >= 5 && i <= 9) return "corn!" >> (8 * (9 - i));
      return 8'(i * 7 + 3);
   endfunction

   task automatic send_hdr(input logic [15:0] len, input bit planted, input bit gap);
      for (int i = 0; i < 28; i++) begin
         step(1'b1, i == 0, hdr_byte(i, len, planted));
         check("R3", {31'd0, alert_o}, 32'd0);
         if (i == 25) check("R4", {15'd0, len_vld_o, len_o}, {16'd1, len});
         else         check("R4", {15'd0, len_vld_o, len_o}, 32'd0);
         if (gap) begin step(1'b0, 1'b1, 8'h63); quiet("R2"); end
      end
   endtask

   task automatic send_payload(input logic [127:0] p, input logic [15:0] mask, input bit gap);
      for (int j = 0; j < 16; j++) begin
         step(1'b1, 1'b0, p[127 - 8*j -: 8]);
         check("R5", {31'd0, alert_o}, {31'd0, mask[j]});
         check("R4", {15'd0, len_vld_o}, 32'd0);
         if (gap) begin step(1'b0, 1'b1, 8'h21); quiet("R2"); end
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; quiet("R1");
      rst_n = 1'b1;
      step(1'b0, 1'b0, 8'h00);
      quiet("R1");

      foreach (TBL[t]) begin
         send_hdr(TBL[t].len, 1'b0, TBL[t].gap);
         send_payload(TBL[t].payload, TBL[t].mask, TBL[t].gap);
      end

      // R3: pattern planted in header bytes 5..9 stays silent
      send_hdr(16'h0042, 1'b1, 1'b0);
      send_payload("................", 16'h0000, 1'b0);

      // R8: start flag mid-match discards the partial "cor"
      send_hdr(16'h0077, 1'b0, 1'b0);
      send_payload("...........xcor", 16'h0000, 1'b0);
      send_hdr(16'h0099, 1'b0, 1'b0);
      send_payload("n!..............", 16'h0000, 1'b0);

      // R8: start flag mid-header restarts header count
      for (int i = 0; i < 10; i++) step(1'b1, i == 0, 8'h63);
      send_hdr(16'h5A5A, 1'b0, 1'b0);
      send_payload(".corn!..........", 16'h0020, 1'b0);

      // R2: valid-low beats between pattern characters
      send_hdr(16'h0010, 1'b0, 1'b0);
      step(1'b1, 1'b0, "c"); step(1'b0, 1'b0, "x"); quiet("R2");
      step(1'b1, 1'b0, "o"); step(1'b1, 1'b0, "r");
      step(1'b0, 1'b1, "!"); quiet("R2");
      step(1'b1, 1'b0, "n"); step(1'b1, 1'b0, "!");
      check("R2", {31'd0, alert_o}, 32'd1);
      step(1'b0, 1'b0, "!");
      check("R5", {31'd0, alert_o}, 32'd0);

      finish_run();
   end
endmodule